// File: doc/BRIEF.md
# Integer Execute Unit with Condition Flags

This block carries out the register-to-register and immediate integer operations on a general register file that sits inside it. The file holds sixteen 32-bit registers. A decoder in front of the block supplies a pre-decoded operation code, a destination index, a source index and a 32-bit immediate, with a one-cycle valid strobe. Most operations finish on the clock edge that accepts them. There are two register-register add forms, two add-immediate forms, a pair move, a small-constant load and a neighbour read.

Only the register-register adds write the four condition bits: negative, zero, signed overflow and carry. Every other operation leaves them as they were. Several operations treat a register and the one at the next index as a pair. The next index wraps from 15 to 0. The iterate operation writes one intermediate sum per cycle and holds `busy` high until its last write is done. While `busy` is high, the block ignores any new strobe.

A lookup port gives combinational read access to any register so that the file's contents can be observed.

Top module: `intexec_unit`

## Requirements
- R1: After reset every register reads zero, all four flags are 0 and `busy` is low.
- R2: Operation code 0 (register add) writes dst = dst + src on the accepting edge. Flag N is bit 31 of the sum and Z is set when the sum is zero. V is the signed overflow of the 32-bit add with no carry-in, and C is its unsigned carry out.
- R3: Operation code 1 (staged register add) gives the same register result and the same flags as code 0 for the same operands.
- R4: Operation code 2 writes dst = src + the sign-extended low 16 bits of `imm`. Bits 31:16 of `imm` have no effect, and the flags are left unchanged.
- R5: Operation code 3 writes dst = src + the full 32-bit `imm` and leaves the flags unchanged.
- R6: Operation code 4 (pair move) writes the old value of src into dst. On the same edge it writes the old value of register src+1 into register dst+1. Both values are read before either write. Indices wrap modulo 16.
- R7: Operation code 5 writes dst with the 4-bit `src_idx` field itself, zero-extended to 32 bits.
- R8: Operation code 6 writes dst with the contents of register src+1, where index 15 + 1 selects register 0.
- R9: Operation code 7 (iterate) first writes dst = reg[src] + k for k = 0..3, one per cycle. It then spends one cycle reading n = reg[src] & 7, and after that writes dst = reg[src] + k for k = 0..n-1. Each write uses the current contents of src. `busy` is high for exactly 5 + n cycles after the accepting edge.
- R10: A strobe that arrives while `busy` is high is ignored: no register or flag changes because of it.
- R11: Operation codes 2 to 7 never change the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Operation strobe, accepted when `busy` is low |
| issue_op | input | 3 | Decoded operation code 0..7 |
| dst_idx | input | 4 | Destination register index |
| src_idx | input | 4 | Source register index, or a small constant for code 5 |
| imm | input | 32 | Immediate operand |
| peek_idx | input | 4 | Register lookup index |
| busy | output | 1 | Iterate sequence in progress |
| peek_data | output | 32 | Contents of register `peek_idx` (combinational) |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
Each single-cycle operation updates its registers and flags on the rising edge that accepts the strobe. The bench drives inputs at a falling edge and removes the strobe at the next falling edge, then reads registers through the lookup port a short delay later, so it always observes the state that follows the accepting edge. For the iterate form, `busy` rises on the accepting edge. The bench counts the falling edges at which `busy` is still high and compares that count with 5 + n, where n comes from its own model of the register file. It checks the final destination value only after `busy` has dropped.

// File: rtl/intexec_pkg.sv
`timescale 1ns/1ps
package intexec_pkg;

    typedef enum logic [2:0] {
        OP_ADD_RR     = 3'd0,
        OP_ADD_RR_TMP = 3'd1,
        OP_ADDI_S16   = 3'd2,
        OP_ADDI_W32   = 3'd3,
        OP_MOV_PAIR   = 3'd4,
        OP_LD_FIELD   = 3'd5,
        OP_MOV_NEXT   = 3'd6,
        OP_ITERATE    = 3'd7
    } exec_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cond_flags_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_RUN_A,
        SEQ_PREP_B,
        SEQ_RUN_B
    } seq_state_e;

endpackage

// File: rtl/intexec_regfile.sv
`timescale 1ns/1ps
module intexec_regfile #(
    parameter int DATA_W = 32,
    parameter int NREG   = 16,
    parameter int IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic [IDX_W-1:0]  rd_c_idx,
    output logic [DATA_W-1:0] rd_c_data,
    input  logic [IDX_W-1:0]  rd_d_idx,
    output logic [DATA_W-1:0] rd_d_data,
    input  logic              wr0_en,
    input  logic [IDX_W-1:0]  wr0_idx,
    input  logic [DATA_W-1:0] wr0_data,
    input  logic              wr1_en,
    input  logic [IDX_W-1:0]  wr1_idx,
    input  logic [DATA_W-1:0] wr1_data
);

    logic [DATA_W-1:0] regs_q [NREG];

    // One storage element per register; the second write port wins a clash.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DATA_W-1:0] reg_d;

        always_comb begin
            reg_d = regs_q[g];
            if (wr0_en && wr0_idx == IDX_W'(g)) reg_d = wr0_data;
            if (wr1_en && wr1_idx == IDX_W'(g)) reg_d = wr1_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[g] <= '0;
            else        regs_q[g] <= reg_d;
        end
    end

    assign rd_a_data = regs_q[rd_a_idx];
    assign rd_b_data = regs_q[rd_b_idx];
    assign rd_c_data = regs_q[rd_c_idx];
    assign rd_d_data = regs_q[rd_d_idx];

endmodule

// File: rtl/intexec_addflags.sv
`timescale 1ns/1ps
module intexec_addflags
    import intexec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] sum,
    output cond_flags_t       flags
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide;

    always_comb begin
        wide    = {1'b0, opa} + {1'b0, opb};
        sum     = wide[MSB:0];
        flags.c = wide[DATA_W];
        flags.n = wide[MSB];
        flags.z = (wide[MSB:0] == '0);
        flags.v = (opa[MSB] == opb[MSB]) && (wide[MSB] != opa[MSB]);
    end

endmodule

// File: rtl/intexec_iter_seq.sv
`timescale 1ns/1ps
module intexec_iter_seq
    import intexec_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 4,
    parameter int FIRST_CNT = 4,
    parameter int MASK_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  dst_in,
    input  logic [IDX_W-1:0]  src_in,
    input  logic [DATA_W-1:0] src_val,
    output logic              busy,
    output logic              wr_en,
    output logic [IDX_W-1:0]  dst,
    output logic [IDX_W-1:0]  src,
    output logic [DATA_W-1:0] offset
);

    localparam int FC_W  = $clog2(FIRST_CNT);
    localparam int CNT_W = (FC_W > MASK_W) ? FC_W : MASK_W;
    localparam logic [CNT_W-1:0] LAST_A = CNT_W'(FIRST_CNT - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] iter;
        logic [CNT_W-1:0] limit;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        wr_en = 1'b0;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (start) begin
                    seq_d.state = SEQ_RUN_A;
                    seq_d.iter  = '0;
                    seq_d.dst   = dst_in;
                    seq_d.src   = src_in;
                end
            end
            SEQ_RUN_A: begin
                wr_en = 1'b1;
                if (seq_q.iter == LAST_A) begin
                    seq_d.state = SEQ_PREP_B;
                    seq_d.iter  = '0;
                end else begin
                    seq_d.iter = seq_q.iter + 1'b1;
                end
            end
            SEQ_PREP_B: begin
                seq_d.limit = CNT_W'(src_val[MASK_W-1:0]);
                seq_d.iter  = '0;
                if (src_val[MASK_W-1:0] == '0) seq_d.state = SEQ_IDLE;
                else                           seq_d.state = SEQ_RUN_B;
            end
            SEQ_RUN_B: begin
                wr_en = 1'b1;
                if (seq_q.iter == seq_q.limit - 1'b1) seq_d.state = SEQ_IDLE;
                else                                  seq_d.iter  = seq_q.iter + 1'b1;
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: SEQ_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign busy   = (seq_q.state != SEQ_IDLE);
    assign dst    = seq_q.dst;
    assign src    = seq_q.src;
    assign offset = DATA_W'(seq_q.iter);

endmodule

// File: rtl/intexec_unit.sv
`timescale 1ns/1ps
module intexec_unit
    import intexec_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NREG      = 16,
    parameter int IDX_W     = $clog2(NREG),
    parameter int NARROW_W  = 16,
    parameter int FIRST_CNT = 4,
    parameter int MASK_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [2:0]        issue_op,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [DATA_W-1:0] imm,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic              busy,
    output logic [DATA_W-1:0] peek_data,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NREG - 1);

    typedef struct packed {
        cond_flags_t flags;
    } unit_regs_t;

    unit_regs_t st_d, st_q;

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
        return (i == TOP_IDX) ? '0 : i + 1'b1;
    endfunction

    exec_op_e          op_e;
    logic              accept;
    logic              seq_busy, seq_wr;
    logic [IDX_W-1:0]  seq_dst, seq_src;
    logic [DATA_W-1:0] seq_offset;
    logic [IDX_W-1:0]  rd_a_idx;
    logic [DATA_W-1:0] rd_a_data, rd_b_data, rd_c_data;
    logic              wr0_en, wr1_en;
    logic [IDX_W-1:0]  wr0_idx, wr1_idx;
    logic [DATA_W-1:0] wr0_data, wr1_data;
    logic [DATA_W-1:0] rr_sum;
    cond_flags_t       rr_flags;
    logic [DATA_W-1:0] imm_narrow;

    assign op_e       = exec_op_e'(issue_op);
    assign accept     = issue_valid && !seq_busy;
    assign rd_a_idx   = seq_busy ? seq_src : src_idx;
    assign imm_narrow = DATA_W'($signed(imm[NARROW_W-1:0]));

    intexec_regfile #(
        .DATA_W (DATA_W),
        .NREG   (NREG),
        .IDX_W  (IDX_W)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (rd_a_idx),
        .rd_a_data (rd_a_data),
        .rd_b_idx  (dst_idx),
        .rd_b_data (rd_b_data),
        .rd_c_idx  (next_idx(src_idx)),
        .rd_c_data (rd_c_data),
        .rd_d_idx  (peek_idx),
        .rd_d_data (peek_data),
        .wr0_en    (wr0_en),
        .wr0_idx   (wr0_idx),
        .wr0_data  (wr0_data),
        .wr1_en    (wr1_en),
        .wr1_idx   (wr1_idx),
        .wr1_data  (wr1_data)
    );

    intexec_addflags #(
        .DATA_W (DATA_W)
    ) u_add (
        .opa   (rd_b_data),
        .opb   (rd_a_data),
        .sum   (rr_sum),
        .flags (rr_flags)
    );

    intexec_iter_seq #(
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W),
        .FIRST_CNT (FIRST_CNT),
        .MASK_W    (MASK_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept && op_e == OP_ITERATE),
        .dst_in  (dst_idx),
        .src_in  (src_idx),
        .src_val (rd_a_data),
        .busy    (seq_busy),
        .wr_en   (seq_wr),
        .dst     (seq_dst),
        .src     (seq_src),
        .offset  (seq_offset)
    );

    always_comb begin
        st_d     = st_q;
        wr0_en   = 1'b0;
        wr0_idx  = dst_idx;
        wr0_data = '0;
        wr1_en   = 1'b0;
        wr1_idx  = next_idx(dst_idx);
        wr1_data = rd_c_data;
        if (seq_wr) begin
            wr0_en   = 1'b1;
            wr0_idx  = seq_dst;
            wr0_data = rd_a_data + seq_offset;
        end else if (accept) begin
            unique case (op_e)
                OP_ADD_RR, OP_ADD_RR_TMP: begin
                    wr0_en     = 1'b1;
                    wr0_data   = rr_sum;
                    st_d.flags = rr_flags;
                end
                OP_ADDI_S16: begin
                    wr0_en   = 1'b1;
                    wr0_data = rd_a_data + imm_narrow;
                end
                OP_ADDI_W32: begin
                    wr0_en   = 1'b1;
                    wr0_data = rd_a_data + imm;
                end
                OP_MOV_PAIR: begin
                    wr0_en   = 1'b1;
                    wr0_data = rd_a_data;
                    wr1_en   = 1'b1;
                end
                OP_LD_FIELD: begin
                    wr0_en   = 1'b1;
                    wr0_data = DATA_W'(src_idx);
                end
                OP_MOV_NEXT: begin
                    wr0_en   = 1'b1;
                    wr0_data = rd_c_data;
                end
                OP_ITERATE: begin
                    wr0_en = 1'b0;
                end
                default: wr0_en = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = seq_busy;
    assign flag_n = st_q.flags.n;
    assign flag_z = st_q.flags.z;
    assign flag_v = st_q.flags.v;
    assign flag_c = st_q.flags.c;

endmodule

// File: rtl/intexec_unit_chk.sv
`timescale 1ns/1ps
module intexec_unit_chk #(
    parameter int FIRST_CNT = 4,
    parameter int MASK_W    = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       issue_valid,
    input logic [2:0] issue_op,
    input logic       busy,
    input logic       flag_n,
    input logic       flag_z,
    input logic       flag_v,
    input logic       flag_c
);

    localparam int MAX_BUSY = FIRST_CNT + 1 + ((1 << MASK_W) - 1);

    logic       acc;
    logic [3:0] flags;
    int         busy_run;

    assign acc   = issue_valid && !busy;
    assign flags = {flag_n, flag_z, flag_v, flag_c};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    AST_NZ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        acc && issue_op <= 3'd1 |=> !(flag_n && flag_z)); // R2

    AST_SINGLE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc && issue_op != 3'd7 |=> !busy); // R2

    AST_IMM_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (issue_op == 3'd2 || issue_op == 3'd3) |=> $stable(flags)); // R4

    AST_ITER_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc && issue_op == 3'd7 |=> busy); // R9

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_run < MAX_BUSY); // R9

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(flags)); // R10

    AST_FLAGS_ONLY_ON_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        acc && issue_op > 3'd1 |=> $stable(flags)); // R11

endmodule

bind intexec_unit intexec_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_op    (issue_op),
    .busy        (busy),
    .flag_n      (flag_n),
    .flag_z      (flag_z),
    .flag_v      (flag_v),
    .flag_c      (flag_c)
);

// File: tb/intexec_unit_tb.sv
`timescale 1ns/1ps
module intexec_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [2:0]  issue_op = '0;
    logic [3:0]  dst_idx = '0;
    logic [3:0]  src_idx = '0;
    logic [31:0] imm = '0;
    logic [3:0]  peek_idx = '0;
    logic        busy;
    logic [31:0] peek_data;
    logic        flag_n, flag_z, flag_v, flag_c;

    int n_checks = 0;
    int n_fails  = 0;

    logic [31:0] mdl [16];
    logic [3:0]  mflags = '0;

    always #2 clk = ~clk;

    intexec_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .issue_op    (issue_op),
        .dst_idx     (dst_idx),
        .src_idx     (src_idx),
        .imm         (imm),
        .peek_idx    (peek_idx),
        .busy        (busy),
        .peek_data   (peek_data),
        .flag_n      (flag_n),
        .flag_z      (flag_z),
        .flag_v      (flag_v),
        .flag_c      (flag_c)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < 16; i++) begin
            peek_idx = 4'(i);
            #0.5;
            chk(req, $sformatf("r%0d", i), peek_data, mdl[i]);
        end
    endtask

    task automatic check_flags(input string req);
        chk(req, "flags nzvc", {28'd0, flag_n, flag_z, flag_v, flag_c}, {28'd0, mflags});
    endtask

    function automatic logic [3:0] add_flags(input logic [31:0] a, input logic [31:0] b);
        logic [32:0] w;
        logic [31:0] s;
        w = {1'b0, a} + {1'b0, b};
        s = w[31:0];
        return {s[31], s == 32'd0, (a[31] == b[31]) && (s[31] != a[31]), w[32]};
    endfunction

    // Reference behaviour for the single-cycle codes, taken from the requirements.
    task automatic model_op(input int op, input int d, input int s, input logic [31:0] iv);
        logic [31:0] a, b;
        a = mdl[s];
        b = mdl[(s + 1) % 16];
        case (op)
            0, 1: begin mflags = add_flags(mdl[d], a); mdl[d] = mdl[d] + a; end
            2: mdl[d] = a + {{16{iv[15]}}, iv[15:0]};
            3: mdl[d] = a + iv;
            4: begin mdl[d] = a; mdl[(d + 1) % 16] = b; end
            5: mdl[d] = 32'(s);
            6: mdl[d] = b;
            default: ;
        endcase
    endtask

    task automatic issue(input int op, input int d, input int s, input logic [31:0] iv);
        @(negedge clk);
        issue_valid = 1'b1;
        issue_op    = 3'(op);
        dst_idx     = 4'(d);
        src_idx     = 4'(s);
        imm         = iv;
        @(negedge clk);
        issue_valid = 1'b0;
        model_op(op, d, s, iv);
    endtask

    task automatic t_reset;
        chk("R1", "busy", {31'd0, busy}, 32'd0);
        check_flags("R1");
        check_regs("R1");
    endtask

    task automatic t_addi_full;
        issue(3, 1, 0, 32'h7fff_ffff);
        issue(3, 2, 0, 32'h0000_0001);
        issue(3, 3, 0, 32'hffff_ffff);
        issue(3, 4, 0, 32'h8000_0000);
        issue(3, 6, 0, 32'h9000_0000);
        issue(3, 7, 0, 32'h9000_0000);
        issue(3, 5, 0, 32'h0000_001d);
        check_regs("R5");
        check_flags("R5");
    endtask

    task automatic t_add_rr;
        issue(0, 1, 2, 0);
        chk("R2", "pos overflow sum", {28'd0, flag_n, flag_z, flag_v, flag_c}, 32'h8 | 32'h2);
        check_flags("R2");
        issue(0, 3, 2, 0);
        chk("R2", "carry to zero", {28'd0, flag_n, flag_z, flag_v, flag_c}, 32'h5);
        issue(0, 4, 4, 0);
        check_flags("R2");
        issue(0, 6, 6, 0);
        check_flags("R2");
        check_regs("R2");
    endtask

    task automatic t_add_tmp;
        logic [3:0] f_plain;
        f_plain = {flag_n, flag_z, flag_v, flag_c};
        issue(1, 7, 7, 0);
        chk("R3", "same flags as plain add", {28'd0, flag_n, flag_z, flag_v, flag_c}, {28'd0, f_plain});
        chk("R3", "same result as plain add", mdl[7], mdl[6]);
        check_regs("R3");
    endtask

    task automatic t_addi_narrow;
        issue(2, 8, 5, 32'habcd_fffe);
        check_regs("R4");
        check_flags("R4");
        issue(2, 9, 5, 32'h1234_0010);
        check_regs("R4");
        check_flags("R11");
    endtask

    task automatic t_pair;
        issue(4, 10, 1, 0);
        check_regs("R6");
        issue(4, 15, 3, 0);
        check_regs("R6");
        issue(4, 4, 5, 0);
        check_regs("R6");
        check_flags("R11");
    endtask

    task automatic t_field;
        issue(5, 12, 13, 0);
        issue(5, 11, 15, 32'hffff_ffff);
        check_regs("R7");
        check_flags("R11");
    endtask

    task automatic t_next;
        issue(6, 13, 15, 0);
        issue(6, 14, 7, 0);
        check_regs("R8");
        check_flags("R11");
    endtask

    task automatic run_iterate(input int d, input int s, input bit poke_busy);
        int n;
        int cyc;
        @(negedge clk);
        issue_valid = 1'b1;
        issue_op    = 3'd7;
        dst_idx     = 4'(d);
        src_idx     = 4'(s);
        imm         = 32'h0;
        @(negedge clk);
        if (poke_busy) begin
            issue_op = 3'd0;
            dst_idx  = 4'd1;
            src_idx  = 4'd2;
        end else begin
            issue_valid = 1'b0;
        end
        for (int k = 0; k < 4; k++) mdl[d] = mdl[s] + 32'(k);
        n = int'(mdl[s] & 32'd7);
        for (int k = 0; k < n; k++) mdl[d] = mdl[s] + 32'(k);
        cyc = 0;
        while (busy) begin
            cyc++;
            @(negedge clk);
            if (poke_busy && cyc == 2) issue_valid = 1'b0;
        end
        issue_valid = 1'b0;
        chk(poke_busy ? "R10" : "R9", "busy cycles", 32'(cyc), 32'(5 + n));
    endtask

    task automatic t_iterate;
        run_iterate(9, 5, 1'b0);
        check_regs("R9");
        issue(3, 12, 0, 32'd13);
        run_iterate(12, 12, 1'b0);
        chk("R9", "self iterate value", mdl[12], 32'd22);
        check_regs("R9");
        issue(3, 2, 0, 32'd8);
        run_iterate(3, 2, 1'b0);
        check_regs("R9");
        check_flags("R11");
    endtask

    task automatic t_busy_ignore;
        run_iterate(14, 5, 1'b1);
        check_regs("R10");
        check_flags("R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addi_full();
        t_add_rr();
        t_add_tmp();
        t_addi_narrow();
        t_pair();
        t_field();
        t_next();
        t_iterate();
        t_busy_ignore();
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule